// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Selector

This block collects interrupt requests for a small microcontroller core. Two active-low external lines, two timer request pulses and a serial-unit request pulse each set their own pending bit. When the core strobes the acknowledge input, the block picks the highest-priority pending source. It registers that source's 16-bit vector address onto its output and clears only that source's pending bit.

The vector table is not one-to-one. The second external line and the first timer share one vector, and the second timer and the serial unit share another. Software tells them apart by other means. A byte-wide configuration register decides whether the second external line is sensed by edge or by level. In edge mode that register also carries a sticky event flag that software can clear but never set. The core's sequencing and the fetch of the vector contents from memory lie outside this block.

Top module: `irq_vector_sel`

## Requirements
- R1: After reset, all pending bits are clear, `any_pend` is 0, `vec_addr` is 0x0000 and `cfg_rdata` reads 0x1F.
- R2: A high-to-low transition on `ext1_n` sets pending source 0. Holding the line low does not set it again after it has been serviced.
- R3: A one-cycle pulse on `tmr1_req`, `tmr2_req` or `ser_req` sets pending source 2, 3 or 4 respectively.
- R4: An acknowledge services pending sources in this order: source 0 (`ext1_n`), source 1 (`ext2_n`), source 2 (timer 1), source 3 (timer 2), source 4 (serial).
- R5: The vectors are 0x1FFA for source 0, 0x1FF8 for sources 1 and 2, and 0x1FF4 for sources 3 and 4.
- R6: On an acknowledge with at least one source pending, `vec_addr` holds the selected vector from the next clock edge. Only the serviced source's pending bit clears, so `any_pend` stays high while others remain.
- R7: An acknowledge with nothing pending has no effect: `vec_addr` keeps its value and `any_pend` stays 0.
- R8: A write to the configuration register behaves as follows. Bit 7 becomes 1 only if it was already 1 and the written bit 7 is 1. Bits 6:5 take the written value. Bits 4:0 always read as 1.
- R9: With configuration bit 5 = 1 (edge mode), a high-to-low transition on `ext2_n` sets pending source 1 and also sets configuration bit 7.
- R10: With configuration bit 5 = 0 (level mode), pending source 1 follows the active-low `ext2_n` line one clock later, and configuration bit 7 is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext1_n | input | 1 | First external interrupt line, active low |
| ext2_n | input | 1 | Second external interrupt line, active low |
| tmr1_req | input | 1 | Timer 1 request pulse |
| tmr2_req | input | 1 | Timer 2 request pulse |
| ser_req | input | 1 | Serial unit request pulse |
| ack | input | 1 | Interrupt acknowledge strobe from the core |
| vec_addr | output | 16 | Vector address of the last serviced source |
| any_pend | output | 1 | High while any source is pending |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration register read value |

## Verification
Every result lands one clock edge after its cause. A line edge or request pulse sampled at a rising edge shows on `any_pend` straight after that edge. An acknowledge seen at a rising edge puts its vector on `vec_addr` and drops the serviced bit at that same edge. A configuration write is visible on `cfg_rdata` after the edge that takes it. The bench changes inputs only on falling edges. Its monitor waits for a rising edge with `ack` high and then compares `vec_addr` and `any_pend` against the queued entry at the next falling edge. The direct checks on `cfg_rdata` and `any_pend` likewise sample one falling edge after the stimulus.

// File: rtl/irq_vector_sel.sv
module irq_vector_sel #(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter logic [AW-1:0] VEC_X1 = 16'h1FFA,
  parameter logic [AW-1:0] VEC_X2 = 16'h1FF8,
  parameter logic [AW-1:0] VEC_T1 = 16'h1FF8,
  parameter logic [AW-1:0] VEC_T2 = 16'h1FF4,
  parameter logic [AW-1:0] VEC_SR = 16'h1FF4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext1_n,
  input  logic          ext2_n,
  input  logic          tmr1_req,
  input  logic          tmr2_req,
  input  logic          ser_req,
  input  logic          ack,
  output logic [AW-1:0] vec_addr,
  output logic          any_pend,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_wdata,
  output logic [CW-1:0] cfg_rdata
);
  localparam int NSRC = 5;
  localparam int LOWW = CW - 3;

  logic [NSRC-1:0] pend, gnt, served;
  logic            x1_q, x2_q;
  logic            flag7;
  logic [1:0]      mode65;
  logic [AW-1:0]   vec_sel;

  wire fall1  = x1_q & ~ext1_n;
  wire fall2  = x2_q & ~ext2_n;
  wire edge2  = mode65[0];
  wire ev2    = edge2 & fall2;

  assign gnt       = pend & (~pend + NSRC'(1));
  assign served    = ack ? gnt : '0;
  assign any_pend  = |pend;
  assign cfg_rdata = {flag7, mode65, {LOWW{1'b1}}};

  always_comb begin
    case (gnt)
      5'b00001: vec_sel = VEC_X1;
      5'b00010: vec_sel = VEC_X2;
      5'b00100: vec_sel = VEC_T1;
      5'b01000: vec_sel = VEC_T2;
      5'b10000: vec_sel = VEC_SR;
      default:  vec_sel = vec_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      x1_q     <= 1'b1;
      x2_q     <= 1'b1;
      vec_addr <= '0;
      flag7    <= 1'b0;
      mode65   <= 2'b00;
    end else begin
      x1_q    <= ext1_n;
      x2_q    <= ext2_n;
      pend[0] <= (pend[0] & ~served[0]) | fall1;
      pend[1] <= edge2 ? ((pend[1] & ~served[1]) | fall2) : ~ext2_n;
      pend[2] <= (pend[2] & ~served[2]) | tmr1_req;
      pend[3] <= (pend[3] & ~served[3]) | tmr2_req;
      pend[4] <= (pend[4] & ~served[4]) | ser_req;
      if (ack && any_pend) vec_addr <= vec_sel;
      if (cfg_we) begin
        flag7  <= (flag7 & cfg_wdata[CW-1]) | ev2;
        mode65 <= cfg_wdata[CW-2:CW-3];
      end else if (ev2) begin
        flag7 <= 1'b1;
      end
    end
  end

  assert_idle_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !any_pend) |=> $stable(vec_addr));

  assert_top_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pend[0]) |=> (vec_addr == VEC_X1));

  assert_timer1_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pend[2:0] == 3'b100) |=> (vec_addr == VEC_T1));

  assert_flag_clear_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_wdata[CW-1] && !ev2) |=> !cfg_rdata[CW-1]);

  assert_low_bits_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[LOWW-1:0] == {LOWW{1'b1}});

  assert_level_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge2 && !ext2_n) |=> any_pend);
endmodule

// File: tb/sim_irq_vector_sel.sv
`timescale 1ns/1ps
module sim_irq_vector_sel;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext1_n = 1'b1, ext2_n = 1'b1;
  logic tmr1_req = 1'b0, tmr2_req = 1'b0, ser_req = 1'b0, ack = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [15:0] vec_addr;
  logic any_pend;
  logic [7:0] cfg_rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [16:0] expq[$];
  string tagq[$];

  always #10 clk = ~clk;

  irq_vector_sel u0 (.clk(clk), .rst_n(rst_n), .ext1_n(ext1_n), .ext2_n(ext2_n),
    .tmr1_req(tmr1_req), .tmr2_req(tmr2_req), .ser_req(ser_req), .ack(ack),
    .vec_addr(vec_addr), .any_pend(any_pend), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ack_exp(logic [15:0] v, logic ap, string tag);
    expq.push_back({ap, v});
    tagq.push_back(tag);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic cfg_wr(logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial forever begin
    @(posedge clk);
    if (ack === 1'b1) begin
      logic [16:0] e;
      string t;
      @(negedge clk);
      e = expq.pop_front();
      t = tagq.pop_front();
      chk({t, " vec"}, {16'h0, vec_addr}, {16'h0, e[15:0]});
      chk({t, " any_pend"}, {31'h0, any_pend}, {31'h0, e[16]});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vec", {16'h0, vec_addr}, 32'h0);
    chk("R1 any_pend", {31'h0, any_pend}, 32'h0);
    chk("R1 cfg", {24'h0, cfg_rdata}, 32'h1F);

    ack_exp(16'h0000, 1'b0, "R7 idle ack");

    tmr2_req = 1; ser_req = 1; @(negedge clk); tmr2_req = 0; ser_req = 0;
    chk("R3 timer2/serial latch", {31'h0, any_pend}, 32'h1);
    ack_exp(16'h1FF4, 1'b1, "R6 timer2 served, serial left");
    ack_exp(16'h1FF4, 1'b0, "R5 serial vector");

    cfg_wr(8'h20);
    chk("R8 mode write", {24'h0, cfg_rdata}, 32'h3F);
    ext1_n = 0; ext2_n = 0; tmr1_req = 1; tmr2_req = 1; ser_req = 1;
    @(negedge clk);
    tmr1_req = 0; tmr2_req = 0; ser_req = 0;
    chk("R9 edge sets flag", {24'h0, cfg_rdata}, 32'hBF);
    ack_exp(16'h1FFA, 1'b1, "R4 ext1 first");
    ack_exp(16'h1FF8, 1'b1, "R9 ext2 edge pending");
    ack_exp(16'h1FF8, 1'b1, "R5 timer1 vector");
    ack_exp(16'h1FF4, 1'b1, "R4 timer2 before serial");
    ack_exp(16'h1FF4, 1'b0, "R6 serial last");
    repeat (3) @(negedge clk);
    chk("R2 held low no repend", {31'h0, any_pend}, 32'h0);
    ext1_n = 1; ext2_n = 1;
    @(negedge clk);

    cfg_wr(8'h80);
    chk("R8 flag kept", {24'h0, cfg_rdata}, 32'h9F);
    cfg_wr(8'h00);
    chk("R8 flag cleared", {24'h0, cfg_rdata}, 32'h1F);
    cfg_wr(8'hE0);
    chk("R8 flag not settable", {24'h0, cfg_rdata}, 32'h7F);
    cfg_wr(8'h00);

    ext2_n = 0; @(negedge clk);
    chk("R10 level pending", {31'h0, any_pend}, 32'h1);
    chk("R10 no flag in level", {24'h0, cfg_rdata}, 32'h1F);
    ext2_n = 1; @(negedge clk);
    chk("R10 level released", {31'h0, any_pend}, 32'h0);

    ext1_n = 0; ser_req = 1; @(negedge clk); ser_req = 0;
    ack_exp(16'h1FFA, 1'b1, "R2 refall ext1 over serial");
    ack_exp(16'h1FF4, 1'b0, "R4 serial after ext1");
    tmr1_req = 1; ser_req = 1; @(negedge clk); tmr1_req = 0; ser_req = 0;
    ack_exp(16'h1FF8, 1'b1, "R4 timer1 over serial");
    ack_exp(16'h1FF4, 1'b0, "R5 serial vector again");
    ack_exp(16'h1FF4, 1'b0, "R7 idle ack keeps vector");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule